// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks reservations for load-linked and store-conditional operations issued by one requesting agent. A small lock table, indexed by the low bits of the line address, holds for each slot a valid flag, the upper address bits of the reserved line and the id of the thread that reserved it. When a write-class memory operation completes, the surrounding cache controller presents the line address, the operation kind, the requester id and whether the line was present in the cache. One cycle later the block answers with a success flag and a numeric result (1 for success, 0 for failure).

A load-linked completion places a reservation. A store-conditional succeeds only while the reservation on its exact line still belongs to the same id, and it always consumes the reservation. Plain stores by the owner drop the reservation. When the cache loses permission for a line, an invalidation strobe removes any reservation on that line. A bypass input forces every answer to success and freezes the table, for configurations that run without reservation semantics.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the table holds no reservation and `rsp_valid_o` is 0; a store-conditional issued before any load-linked fails.
- R2: A present load-linked (op code 0) reserves its line for the given requester id; a following store-conditional (op code 1) by that id to that line succeeds.
- R3: A store-conditional succeeds only when its exact line (index and upper bits) is reserved by the same id; the result value is 1 on success and 0 on failure, zero-extended to `RESULT_W` bits.
- R4: Every present store-conditional removes the reservation on its line, whether it succeeds or fails and whoever owns it.
- R5: A present plain store (op code 2) by the owning id removes the reservation; a plain store by another id leaves it in place.
- R6: An invalidation of a line removes a reservation on that exact line whatever its owner; an invalidation of another line sharing the same slot leaves it in place.
- R7: An operation whose line is not present in the cache reports success and changes no reservation.
- R8: Load-linked and other operations (op code 3) always report success; op code 3 changes no reservation.
- R9: An invalidation of the same line in the same cycle as a completion wins: a store-conditional then fails, and a load-linked reports success but leaves no reservation.
- R10: While `bypass_i` is 1 every completion reports success and neither completions nor invalidations change the table.
- R11: `rsp_valid_o` is 1 exactly in the cycle after a cycle with `cmp_valid_i` at 1.
- R12: Each slot holds one line: a load-linked to a different line that maps to the same slot replaces the earlier reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | Force success, freeze the table |
| cmp_valid_i | input | 1 | Completion strobe |
| cmp_op_i | input | 2 | Operation: 0 load-linked, 1 store-conditional, 2 plain store, 3 other |
| cmp_addr_i | input | ADDR_W | Line address of the completion |
| cmp_id_i | input | ID_W | Requester id |
| cmp_present_i | input | 1 | Line present in the cache |
| inv_valid_i | input | 1 | Permission-loss strobe |
| inv_addr_i | input | ADDR_W | Line address losing permission |
| rsp_valid_o | output | 1 | Answer valid |
| rsp_ok_o | output | 1 | Success flag |
| rsp_value_o | output | RESULT_W | Result value, 1 or 0 |

## Verification
A completion and an invalidation can strike the table in the same cycle, either on the very same line, on two lines sharing one slot, or on unrelated slots. Directed sequences place a store-conditional or load-linked together with an invalidation of the same line, then probe the slot with a later store-conditional; random traffic over a narrow address pool produces all three overlaps often. A bench model applies the invalidation against the state before the edge and then the completion's update, and each answer is compared with that model.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LINK  = 2'd0,
        OP_COND  = 2'd1,
        OP_STORE = 2'd2,
        OP_OTHER = 2'd3
    } llsc_op_e;

endpackage

// File: rtl/llsc_lock_table.sv
module llsc_lock_table #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 7,
    parameter int ID_W      = 2,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] a_idx_i,
    output logic             a_valid_o,
    output logic [TAG_W-1:0] a_tag_o,
    output logic [ID_W-1:0]  a_owner_o,
    input  logic [IDX_W-1:0] b_idx_i,
    output logic             b_valid_o,
    output logic [TAG_W-1:0] b_tag_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_valid_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [ID_W-1:0]  wr_owner_i,
    input  logic             clr_en_i,
    input  logic [IDX_W-1:0] clr_idx_i
);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [ID_W-1:0]  owner;
    } slot_t;

    slot_t [NUM_LINES-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (clr_en_i) begin
            tab_d[clr_idx_i].valid = 1'b0;
        end
        // the completion's update is applied last so it wins on a shared slot
        if (wr_en_i) begin
            tab_d[wr_idx_i].valid = wr_valid_i;
            tab_d[wr_idx_i].tag   = wr_tag_i;
            tab_d[wr_idx_i].owner = wr_owner_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign a_valid_o = tab_q[a_idx_i].valid;
    assign a_tag_o   = tab_q[a_idx_i].tag;
    assign a_owner_o = tab_q[a_idx_i].owner;
    assign b_valid_o = tab_q[b_idx_i].valid;
    assign b_tag_o   = tab_q[b_idx_i].tag;

endmodule

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
    parameter int TAG_W = 7
) (
    input  logic             slot_valid_i,
    input  logic [TAG_W-1:0] slot_tag_i,
    input  logic [TAG_W-1:0] query_tag_i,
    output logic             hit_o
);

    assign hit_o = slot_valid_i && (slot_tag_i == query_tag_i);

endmodule

// File: rtl/llsc_resolve.sv
module llsc_resolve
    import llsc_pkg::*;
(
    input  logic       bypass_i,
    input  logic       cmp_valid_i,
    input  logic [1:0] cmp_op_i,
    input  logic       cmp_present_i,
    input  logic       line_hit_i,
    input  logic       owner_match_i,
    input  logic       inv_valid_i,
    input  logic       inv_same_i,
    input  logic       inv_hit_i,
    output logic       ok_o,
    output logic       wr_en_o,
    output logic       wr_valid_o,
    output logic       clr_en_o
);

    llsc_op_e op;
    logic     active;
    logic     held;

    assign op     = llsc_op_e'(cmp_op_i);
    assign active = cmp_valid_i && !bypass_i && cmp_present_i;
    assign held   = line_hit_i && owner_match_i && !inv_same_i;

    always_comb begin
        ok_o       = 1'b1;
        wr_en_o    = 1'b0;
        wr_valid_o = 1'b0;
        if (active) begin
            unique case (op)
                OP_LINK: begin
                    wr_en_o    = !inv_same_i;
                    wr_valid_o = 1'b1;
                end
                OP_COND: begin
                    ok_o    = held;
                    wr_en_o = line_hit_i;
                end
                OP_STORE: begin
                    wr_en_o = line_hit_i && owner_match_i;
                end
                default: begin
                end
            endcase
        end
    end

    assign clr_en_o = inv_valid_i && !bypass_i && inv_hit_i;

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 10,
    parameter int ID_W      = 2,
    parameter int RESULT_W  = 8,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bypass_i,
    input  logic                cmp_valid_i,
    input  logic [1:0]          cmp_op_i,
    input  logic [ADDR_W-1:0]   cmp_addr_i,
    input  logic [ID_W-1:0]     cmp_id_i,
    input  logic                cmp_present_i,
    input  logic                inv_valid_i,
    input  logic [ADDR_W-1:0]   inv_addr_i,
    output logic                rsp_valid_o,
    output logic                rsp_ok_o,
    output logic [RESULT_W-1:0] rsp_value_o
);

    typedef struct packed {
        logic valid;
        logic ok;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [IDX_W-1:0] cmp_idx, inv_idx;
    logic [TAG_W-1:0] cmp_tag, inv_tag;
    logic             a_valid, b_valid;
    logic [TAG_W-1:0] a_tag, b_tag;
    logic [ID_W-1:0]  a_owner;
    logic             line_hit, inv_hit, owner_match, inv_same;
    logic             ok, wr_en, wr_valid, clr_en;

    assign cmp_idx = cmp_addr_i[IDX_W-1:0];
    assign cmp_tag = cmp_addr_i[ADDR_W-1:IDX_W];
    assign inv_idx = inv_addr_i[IDX_W-1:0];
    assign inv_tag = inv_addr_i[ADDR_W-1:IDX_W];

    llsc_lock_table #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .ID_W      (ID_W)
    ) table_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .a_idx_i    (cmp_idx),
        .a_valid_o  (a_valid),
        .a_tag_o    (a_tag),
        .a_owner_o  (a_owner),
        .b_idx_i    (inv_idx),
        .b_valid_o  (b_valid),
        .b_tag_o    (b_tag),
        .wr_en_i    (wr_en),
        .wr_idx_i   (cmp_idx),
        .wr_valid_i (wr_valid),
        .wr_tag_i   (cmp_tag),
        .wr_owner_i (cmp_id_i),
        .clr_en_i   (clr_en),
        .clr_idx_i  (inv_idx)
    );

    llsc_line_match #(.TAG_W(TAG_W)) cmp_match_i (
        .slot_valid_i (a_valid),
        .slot_tag_i   (a_tag),
        .query_tag_i  (cmp_tag),
        .hit_o        (line_hit)
    );

    llsc_line_match #(.TAG_W(TAG_W)) inv_match_i (
        .slot_valid_i (b_valid),
        .slot_tag_i   (b_tag),
        .query_tag_i  (inv_tag),
        .hit_o        (inv_hit)
    );

    assign owner_match = (a_owner == cmp_id_i);
    assign inv_same    = inv_valid_i && (inv_addr_i == cmp_addr_i);

    llsc_resolve resolve_i (
        .bypass_i      (bypass_i),
        .cmp_valid_i   (cmp_valid_i),
        .cmp_op_i      (cmp_op_i),
        .cmp_present_i (cmp_present_i),
        .line_hit_i    (line_hit),
        .owner_match_i (owner_match),
        .inv_valid_i   (inv_valid_i),
        .inv_same_i    (inv_same),
        .inv_hit_i     (inv_hit),
        .ok_o          (ok),
        .wr_en_o       (wr_en),
        .wr_valid_o    (wr_valid),
        .clr_en_o      (clr_en)
    );

    always_comb begin
        rsp_d.valid = cmp_valid_i;
        rsp_d.ok    = cmp_valid_i ? ok : rsp_q.ok;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_ok_o    = rsp_q.ok;
    assign rsp_value_o = RESULT_W'(rsp_q.ok);

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int ADDR_W   = 10,
    parameter int RESULT_W = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                bypass_i,
    input logic                cmp_valid_i,
    input logic [1:0]          cmp_op_i,
    input logic [ADDR_W-1:0]   cmp_addr_i,
    input logic                cmp_present_i,
    input logic                inv_valid_i,
    input logic [ADDR_W-1:0]   inv_addr_i,
    input logic                rsp_valid_o,
    input logic                rsp_ok_o,
    input logic [RESULT_W-1:0] rsp_value_o
);

    assert_rsp_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_valid_i |=> rsp_valid_o);

    assert_rsp_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmp_valid_i |=> !rsp_valid_o);

    assert_value_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> (rsp_value_o == RESULT_W'(rsp_ok_o)));

    assert_link_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_valid_i && cmp_op_i == 2'd0) |=> rsp_ok_o);

    assert_absent_ok_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_valid_i && !cmp_present_i) |=> rsp_ok_o);

    assert_bypass_ok_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_valid_i && bypass_i) |=> rsp_ok_o);

    assert_inv_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_valid_i && cmp_op_i == 2'd1 && cmp_present_i && !bypass_i &&
         inv_valid_i && inv_addr_i == cmp_addr_i) |=> !rsp_ok_o);

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .ADDR_W   (ADDR_W),
    .RESULT_W (RESULT_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bypass_i      (bypass_i),
    .cmp_valid_i   (cmp_valid_i),
    .cmp_op_i      (cmp_op_i),
    .cmp_addr_i    (cmp_addr_i),
    .cmp_present_i (cmp_present_i),
    .inv_valid_i   (inv_valid_i),
    .inv_addr_i    (inv_addr_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_ok_o      (rsp_ok_o),
    .rsp_value_o   (rsp_value_o)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;

    localparam int NUM_LINES = 8;
    localparam int ADDR_W    = 10;
    localparam int ID_W      = 2;
    localparam int RESULT_W  = 8;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int TAG_W     = ADDR_W - IDX_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bypass = 1'b0;
    logic                cmp_valid = 1'b0;
    logic [1:0]          cmp_op = 2'd0;
    logic [ADDR_W-1:0]   cmp_addr = '0;
    logic [ID_W-1:0]     cmp_id = '0;
    logic                cmp_present = 1'b1;
    logic                inv_valid = 1'b0;
    logic [ADDR_W-1:0]   inv_addr = '0;
    logic                rsp_valid;
    logic                rsp_ok;
    logic [RESULT_W-1:0] rsp_value;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit               m_v   [NUM_LINES];
    logic [TAG_W-1:0] m_tag [NUM_LINES];
    logic [ID_W-1:0]  m_own [NUM_LINES];

    always #4 clk = ~clk;

    llsc_monitor #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .ID_W      (ID_W),
        .RESULT_W  (RESULT_W)
    ) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .bypass_i      (bypass),
        .cmp_valid_i   (cmp_valid),
        .cmp_op_i      (cmp_op),
        .cmp_addr_i    (cmp_addr),
        .cmp_id_i      (cmp_id),
        .cmp_present_i (cmp_present),
        .inv_valid_i   (inv_valid),
        .inv_addr_i    (inv_addr),
        .rsp_valid_o   (rsp_valid),
        .rsp_ok_o      (rsp_ok),
        .rsp_value_o   (rsp_value)
    );

    task automatic check(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at the falling edge, judge the registered answer one edge later
    task automatic step(input bit v, input logic [1:0] op, input logic [ADDR_W-1:0] a,
                        input logic [ID_W-1:0] id, input bit pres, input bit byp,
                        input bit iv, input logic [ADDR_W-1:0] ia, input string req);
        int ix = int'(a[IDX_W-1:0]);
        int jx = int'(ia[IDX_W-1:0]);
        bit hit  = m_v[ix] && (m_tag[ix] == a[ADDR_W-1:IDX_W]);
        bit own  = hit && (m_own[ix] == id);
        bit same = iv && (ia == a);
        bit exp_ok = 1'b1;
        bit wr = 1'b0;
        bit wv = 1'b0;
        if (v && !byp && pres) begin
            case (op)
                2'd0: begin wr = !same; wv = 1'b1; end
                2'd1: begin exp_ok = own && !same; wr = hit; end
                2'd2: wr = own;
                default: ;
            endcase
        end
        if (iv && !byp && m_v[jx] && (m_tag[jx] == ia[ADDR_W-1:IDX_W])) m_v[jx] = 1'b0;
        if (wr) begin
            m_v[ix] = wv; m_tag[ix] = a[ADDR_W-1:IDX_W]; m_own[ix] = id;
        end
        cmp_valid = v; cmp_op = op; cmp_addr = a; cmp_id = id; cmp_present = pres;
        bypass = byp; inv_valid = iv; inv_addr = ia;
        @(posedge clk);
        @(negedge clk);
        cmp_valid = 1'b0; inv_valid = 1'b0; bypass = 1'b0;
        check(rsp_valid == v, {req, " valid"}, int'(rsp_valid), int'(v));
        if (v) begin
            check(rsp_ok == exp_ok, {req, " ok"}, int'(rsp_ok), int'(exp_ok));
            check(rsp_value == RESULT_W'(exp_ok), {req, " value"}, int'(rsp_value), int'(exp_ok));
        end
    endtask

    task automatic op1(input logic [1:0] op, input int a, input int id, input string req);
        step(1'b1, op, ADDR_W'(a), ID_W'(id), 1'b1, 1'b0, 1'b0, '0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_LINES; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_own[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 reset valid", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 idle valid", int'(rsp_valid), 0);
        op1(2'd1, 5, 1, "R1 cond before link");

        op1(2'd0, 5, 1, "R2 link");
        op1(2'd1, 5, 1, "R2 cond same id");
        op1(2'd1, 5, 1, "R4 second cond");
        op1(2'd0, 5, 1, "R3 link");
        op1(2'd1, 5, 2, "R3 cond other id");
        op1(2'd1, 5, 1, "R4 failed cond consumed lock");

        op1(2'd0, 6, 0, "R5 link");
        op1(2'd2, 6, 3, "R5 store other id");
        op1(2'd1, 6, 0, "R5 lock kept");
        op1(2'd0, 6, 0, "R5 link again");
        op1(2'd2, 6, 0, "R5 store owner");
        op1(2'd1, 6, 0, "R5 lock dropped");

        op1(2'd0, 7, 2, "R6 link");
        step(1'b0, 2'd0, '0, '0, 1'b1, 1'b0, 1'b1, ADDR_W'(7 + NUM_LINES), "R6 inv other line");
        op1(2'd1, 7, 2, "R6 lock kept");
        op1(2'd0, 7, 2, "R6 link again");
        step(1'b0, 2'd0, '0, '0, 1'b1, 1'b0, 1'b1, ADDR_W'(7), "R6 inv line");
        op1(2'd1, 7, 2, "R6 lock dropped");

        step(1'b1, 2'd1, ADDR_W'(3), 2'd0, 1'b0, 1'b0, 1'b0, '0, "R7 absent cond");
        op1(2'd0, 3, 0, "R7 link");
        step(1'b1, 2'd1, ADDR_W'(3), 2'd0, 1'b0, 1'b0, 1'b0, '0, "R7 absent cond keeps");
        op1(2'd1, 3, 0, "R7 lock kept");

        op1(2'd0, 0, 0, "R8 link");
        op1(2'd3, 0, 0, "R8 other op");
        op1(2'd1, 0, 0, "R8 lock kept");

        op1(2'd0, 2, 1, "R9 link");
        step(1'b1, 2'd1, ADDR_W'(2), 2'd1, 1'b1, 1'b0, 1'b1, ADDR_W'(2), "R9 cond with inv");
        op1(2'd1, 2, 1, "R9 lock gone");
        step(1'b1, 2'd0, ADDR_W'(2), 2'd1, 1'b1, 1'b0, 1'b1, ADDR_W'(2), "R9 link with inv");
        op1(2'd1, 2, 1, "R9 no lock placed");

        step(1'b1, 2'd1, ADDR_W'(4), 2'd1, 1'b1, 1'b1, 1'b0, '0, "R10 bypass cond");
        step(1'b1, 2'd0, ADDR_W'(4), 2'd1, 1'b1, 1'b1, 1'b0, '0, "R10 bypass link");
        op1(2'd1, 4, 1, "R10 no lock placed");
        op1(2'd0, 4, 1, "R10 link");
        step(1'b0, 2'd0, '0, '0, 1'b1, 1'b1, 1'b1, ADDR_W'(4), "R10 bypass inv");
        op1(2'd1, 4, 1, "R10 lock kept");

        op1(2'd0, 1, 0, "R12 link line A");
        op1(2'd0, 1 + NUM_LINES, 0, "R12 link line B");
        op1(2'd1, 1, 0, "R12 line A replaced");
        op1(2'd1, 1 + NUM_LINES, 0, "R12 line B held");

        step(1'b0, 2'd0, '0, '0, 1'b1, 1'b0, 1'b0, '0, "R11 idle");

        void'($urandom(32'd7741));
        for (int n = 0; n < 4000; n++) begin
            bit v    = ($urandom % 8) != 0;
            bit pres = ($urandom % 8) != 0;
            bit byp  = ($urandom % 16) == 0;
            bit iv   = ($urandom % 4) == 0;
            logic [1:0] op = 2'($urandom % 4);
            logic [ADDR_W-1:0] a  = ADDR_W'((($urandom % 2) << IDX_W) | ($urandom % 4));
            logic [ADDR_W-1:0] ia = ($urandom % 2 == 0) ? a :
                ADDR_W'((($urandom % 2) << IDX_W) | ($urandom % 4));
            logic [ID_W-1:0] id = ID_W'($urandom % 4);
            string req;
            if (byp) req = "R10 random";
            else if (!v) req = "R11 random";
            else if (!pres) req = "R7 random";
            else if (iv && ia == a) req = "R9 random";
            else if (op == 2'd1) req = "R3 random";
            else if (op == 2'd2) req = "R5 random";
            else req = "R8 random";
            step(v, op, a, id, pres, byp, iv, ia, req);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule